// File: doc/BRIEF.md
# Framed Synchronous Serial Port

A 16-bit synchronous serial port that runs as clock master or as clock slave and exchanges one word per transfer, most significant bit first. The host side is two valid/ready streams: words offered on the transmit stream wait in a one-word holding buffer until the shift register is free, and words assembled by the shift register are offered on the receive stream. A transmit word is taken only while `tx_ready` is high. A received word stays on `rx_data` with `rx_valid` high until the host raises `rx_ready`. The port gives no other back-pressure: a word that completes while the previous one is still unread is dropped.

The serial side has a clock output and a clock input, a data output, a data input, and a select line split into input, output and output-enable. Without framing, the select line is an active-low chip select. With framing, it carries an active-high pulse one serial clock period long that marks the start of a word. Depending on a control pin, the port either drives this pulse or waits for one from the far end. In both cases the first data bit period begins at the falling serial clock edge that ends the pulse.

As master, the port divides the system clock in two cascaded stages: a coarse stage of 1, 4, 16 or 64 and a fine stage of 1 to 8. Each product of the two is one half period of the serial clock. The serial clock idles low. Data out changes after falling edges and data in is sampled on rising edges. As slave, the clock, select and data inputs pass through two-flop synchronizers. The external clock must therefore stay at each level for at least four system clocks.

Top module: `fspi_port`

## Requirements
- R1: As master, the serial clock period is 2·P·S system clocks, where P is 1, 4, 16 or 64 for `pre_sel` codes 0, 1, 2 and 3 and S is `sec_div`+1. The clock is low whenever no transfer is running.
- R2: A transfer sends the 16-bit transmit word MSB first on `sdo`, which changes only after falling clock edges. It samples `sdi` on each of the 16 rising edges and shifts the bit into the LSB end, so the first bit received ends up as bit 15 of the received word.
- R3: `tx_ready` is high exactly when the holding buffer is empty. An accepted word moves to the shift register once no transfer is running, after which `tx_ready` goes high again. A second word offered during a transfer is held with `tx_ready` low until the shift register takes it.
- R4: At the end of the 16th data bit, the received word appears on `rx_data` and `rx_valid` is raised. Both are held until `rx_ready` is high. If a word completes while `rx_valid` is high and `rx_ready` is low, that new word is discarded.
- R5: As master without framing, `sel_out` is low for the whole transfer and high while idle.
- R6: With framing and a locally generated pulse (`sync_in_mode`=0), `sel_out` is high for exactly one serial clock period, from one falling edge to the next. The MSB is sampled at the first rising edge after the pulse. A master starts the pulse as soon as a word is loaded. A slave starts it at the first falling edge after a word is loaded.
- R7: With framing and `sync_in_mode`=1, a high `sel_in` seen at a rising edge marks the pulse, and shifting starts at the next falling edge. A master runs its clock while a word is pending so that the pulse can be observed.
- R8: In framed slave mode with a received pulse, no word starts while no pulse arrives. A pulse that arrives during a word is ignored and does not start a new word after that word ends.
- R9: As slave without framing, a low `sel_in` selects the port. If `sel_in` goes high in the middle of a word, the partial word is dropped with no receive word, and the loaded transmit word is dropped with it.
- R10: As slave with an empty transmit path, the port sends all zeros.
- R11: `sel_oe` is 1 when framing is on and the pulse is generated locally, 0 when framing is on and the pulse is received, and equal to `master` when framing is off.
- R12: After reset, `tx_ready` is 1, `rx_valid` is 0, `sclk_out` is 0 and `sel_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master | input | 1 | 1 = drive the serial clock, 0 = follow `sclk_in` |
| frame_en | input | 1 | 1 = select line carries a frame pulse |
| sync_in_mode | input | 1 | With framing: 1 = receive the pulse, 0 = generate it |
| pre_sel | input | 2 | Coarse divider code: 1, 4, 16, 64 |
| sec_div | input | 3 | Fine divider minus one (1 to 8) |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding buffer empty |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Received word available |
| rx_ready | input | 1 | Host takes the received word |
| rx_data | output | 16 | Received word |
| sclk_in | input | 1 | Serial clock from the far end (slave) |
| sclk_out | output | 1 | Generated serial clock (master) |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sel_in | input | 1 | Select or frame pulse from the far end |
| sel_out | output | 1 | Select or frame pulse driven by the port |
| sel_oe | output | 1 | Output enable for the select line |

## Verification
The master path is swept over every fine divider at three coarse settings and over the extremes of the largest one. For each setting the measured clock period and a different pair of words are compared, which separates errors in the divider cascade from errors in bit order. Back-to-back master words with the receive side left unread show whether the holding buffer and the drop rule interact as stated. Slave transfers are driven from an external clock with no pulse, with a pulse in the middle of a word, and with select released partway through a word. These cases separate the start rules of the framed modes from the abort rule of the unframed mode. The received and generated pulse directions are each checked for the pulse width and for which falling edge starts the data.

// File: rtl/fspi_pkg.sv
package fspi_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_SHIFT} fspi_state_e;
endpackage

// File: rtl/fspi_sync.sv
module fspi_sync #(
  parameter int N = 3,
  parameter logic [N-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fspi_clkdiv.sv
module fspi_clkdiv #(
  parameter int PRE_SEL_W    = 2,
  parameter int PRE_STEP_LOG = 2,
  parameter int SEC_W        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic [PRE_SEL_W-1:0] pre_sel,
  input  logic [SEC_W-1:0]     sec_div,
  output logic                 half_tick
);
  localparam int PCNT_W = PRE_STEP_LOG * ((1 << PRE_SEL_W) - 1);

  logic [PCNT_W-1:0] pcnt;
  logic [PCNT_W:0]   pre_lim;
  logic [SEC_W-1:0]  scnt;
  logic              pre_en;

  always_comb begin
    pre_lim   = ((PCNT_W+1)'(1) << (PRE_STEP_LOG * int'(pre_sel))) - (PCNT_W+1)'(1);
    pre_en    = run && (pcnt == pre_lim[PCNT_W-1:0]);
    half_tick = pre_en && (scnt == sec_div);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt <= '0;
      scnt <= '0;
    end else if (!run) begin
      pcnt <= '0;
      scnt <= '0;
    end else begin
      pcnt <= pre_en ? '0 : pcnt + 1'b1;
      if (pre_en) scnt <= (scnt == sec_div) ? '0 : scnt + 1'b1;
    end
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_tick && !(pre_sel == '0 && sec_div == '0)) |=> !half_tick);
endmodule

// File: rtl/fspi_shifter.sv
module fspi_shifter import fspi_pkg::*; #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         master,
  input  logic         frame_en,
  input  logic         sync_in_mode,
  input  logic         rise,
  input  logic         fall,
  input  logic         sel_lvl,
  input  logic         din,
  input  logic         tx_pend,
  input  logic [W-1:0] tx_word,
  output logic         take,
  output logic         sdo,
  output logic         busy,
  output logic         in_sync,
  output logic         loaded,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int CNT_W = $clog2(W);

  fspi_state_e     state;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     sr;
  logic             rbit;
  logic             go_shift, go_sync, last, abort;

  always_comb begin
    take     = (state == ST_IDLE) && tx_pend && !loaded;
    last     = (cnt == CNT_W'(W-1));
    done     = (state == ST_SHIFT) && fall && last;
    abort    = !master && !frame_en && sel_lvl;
    go_shift = !frame_en && (master ? loaded : !sel_lvl);
    go_sync  = frame_en && (sync_in_mode ? (rise && sel_lvl && (loaded || !master))
                                         : (loaded && (master || fall)));
    rx_word  = {sr[W-2:0], rbit};
    sdo      = sr[W-1];
    busy     = (state != ST_IDLE);
    in_sync  = (state == ST_SYNC);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sr     <= '0;
      rbit   <= 1'b0;
      loaded <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (take) begin
            sr     <= tx_word;
            loaded <= 1'b1;
          end
          cnt <= '0;
          if (go_shift)     state <= ST_SHIFT;
          else if (go_sync) state <= ST_SYNC;
        end
        ST_SYNC: begin
          if (fall) state <= ST_SHIFT;
        end
        default: begin
          if (rise) rbit <= din;
          if (done) begin
            sr     <= '0;
            loaded <= 1'b0;
            cnt    <= '0;
            state  <= ST_IDLE;
          end else if (abort) begin
            sr     <= '0;
            loaded <= 1'b0;
            cnt    <= '0;
            state  <= ST_IDLE;
          end else if (fall) begin
            sr  <= {sr[W-2:0], rbit};
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  // R6
  sync_to_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SYNC && fall) |=> (state == ST_SHIFT && cnt == '0));

  // R8
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && state == ST_SHIFT && !fall) |=> state == ST_SHIFT);

  // R3
  take_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> loaded);

  // R2
  idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (cnt == '0));
endmodule

// File: rtl/fspi_port.sv
module fspi_port import fspi_pkg::*; #(
  parameter int WORD_W       = 16,
  parameter int PRE_SEL_W    = 2,
  parameter int PRE_STEP_LOG = 2,
  parameter int SEC_W        = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 master,
  input  logic                 frame_en,
  input  logic                 sync_in_mode,
  input  logic [PRE_SEL_W-1:0] pre_sel,
  input  logic [SEC_W-1:0]     sec_div,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic [WORD_W-1:0]    tx_data,
  output logic                 rx_valid,
  input  logic                 rx_ready,
  output logic [WORD_W-1:0]    rx_data,
  input  logic                 sclk_in,
  output logic                 sclk_out,
  input  logic                 sdi,
  output logic                 sdo,
  input  logic                 sel_in,
  output logic                 sel_out,
  output logic                 sel_oe
);
  logic [2:0]        pin_s;
  logic              sclk_s, sel_s, sdi_s, sclk_d;
  logic              run, half_tick, sclk_q;
  logic              rise, fall, din;
  logic              take, busy, in_sync, loaded, done;
  logic              tx_full, rx_full;
  logic [WORD_W-1:0] tx_buf, rx_buf, rx_word;

  fspi_sync #(.N(3), .INIT(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sclk_in, sel_in, sdi}), .q(pin_s)
  );
  assign {sclk_s, sel_s, sdi_s} = pin_s;

  assign run = master && (busy || (loaded && frame_en && sync_in_mode));

  fspi_clkdiv #(.PRE_SEL_W(PRE_SEL_W), .PRE_STEP_LOG(PRE_STEP_LOG), .SEC_W(SEC_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(run), .pre_sel(pre_sel), .sec_div(sec_div),
    .half_tick(half_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      if (!run)           sclk_q <= 1'b0;
      else if (half_tick) sclk_q <= !sclk_q;
    end
  end

  always_comb begin
    rise = master ? (half_tick && !sclk_q) : (sclk_s && !sclk_d);
    fall = master ? (half_tick && sclk_q)  : (!sclk_s && sclk_d);
    din  = master ? sdi : sdi_s;
  end

  fspi_shifter #(.W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .master(master), .frame_en(frame_en),
    .sync_in_mode(sync_in_mode), .rise(rise), .fall(fall), .sel_lvl(sel_s),
    .din(din), .tx_pend(tx_full), .tx_word(tx_buf), .take(take), .sdo(sdo),
    .busy(busy), .in_sync(in_sync), .loaded(loaded), .done(done), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_buf  <= '0;
      rx_full <= 1'b0;
      rx_buf  <= '0;
    end else begin
      if (tx_valid && !tx_full) begin
        tx_buf  <= tx_data;
        tx_full <= 1'b1;
      end else if (take) begin
        tx_full <= 1'b0;
      end
      if (done && (!rx_full || rx_ready)) begin
        rx_buf  <= rx_word;
        rx_full <= 1'b1;
      end else if (rx_full && rx_ready) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_comb begin
    tx_ready = !tx_full;
    rx_valid = rx_full;
    rx_data  = rx_buf;
    sclk_out = sclk_q;
    sel_oe   = frame_en ? !sync_in_mode : master;
    sel_out  = frame_en ? (in_sync && !sync_in_mode) : !(master && busy);
  end

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  // R3
  tx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  // R1
  clk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (master && !busy && !(frame_en && sync_in_mode)) |-> !sclk_out);
endmodule

// File: tb/fspi_port_tb.sv
module fspi_port_tb;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master = 1'b1, frame_en = 1'b0, sync_in_mode = 1'b0;
  logic [1:0] pre_sel = '0;
  logic [2:0] sec_div = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_ready, rx_valid, sclk_out, sdo, sel_out, sel_oe;
  logic [15:0] rx_data;
  logic sclk_in = 1'b0, sdi = 1'b0, sel_in = 1'b1;

  int n_cmp = 0, n_bad = 0;

  always #2 clk = !clk;

  fspi_port u_dut (
    .clk(clk), .rst_n(rst_n), .master(master), .frame_en(frame_en),
    .sync_in_mode(sync_in_mode), .pre_sel(pre_sel), .sec_div(sec_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sdi(sdi), .sdo(sdo),
    .sel_in(sel_in), .sel_out(sel_out), .sel_oe(sel_oe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk); tx_valid = 1'b1; tx_data = w;
    @(negedge clk); tx_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  // mode 0: no framing, 1: pulse generated, 2: pulse received
  task automatic mpoll(input int mode, input logic [15:0] bw, output logic [15:0] got,
                       output int per, output int selw, output int cs_bad);
    int nb, t, r1, r2;
    logic ps, cs, armed;
    nb = 0; t = 0; r1 = -1; r2 = -1;
    got = '0; selw = 0; cs_bad = 0;
    armed = (mode == 0);
    sdi = bw[15];
    ps = sclk_out;
    while (nb < 16 && t < 30000) begin
      @(negedge clk); t++;
      cs = sclk_out;
      if (mode == 1 && sel_out) selw++;
      if (cs && !ps && armed) begin
        got = {got[14:0], sdo};
        if (r1 < 0) r1 = t; else if (r2 < 0) r2 = t;
      end
      if (!cs && ps) begin
        if (armed) begin
          nb++;
          if (nb < 16) sdi = bw[15-nb];
        end else if (mode == 2 && sel_in) begin
          sel_in = 1'b0; armed = 1'b1;
        end else if (mode == 2) begin
          sel_in = 1'b1;
        end else if (mode == 1 && !sel_out) begin
          armed = 1'b1;
        end
      end
      if (mode == 0 && r1 >= 0 && nb < 16 && sel_out) cs_bad++;
      ps = cs;
    end
    per = r2 - r1;
  endtask

  task automatic scyc(input logic s, input logic d, output logic q, output logic so);
    sel_in = s; sdi = d;
    repeat (H) @(negedge clk);
    q = sdo; so = sel_out;
    sclk_in = 1'b1;
    repeat (H) @(negedge clk);
    sclk_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R12 watchdog act=%0d exp=<%0d", 200000, 200000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] hw, bw, got, ha, ba, hb, bb;
    logic q, so;
    int per, selw, csb, k, sel_hi_cnt;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 tx_ready", tx_ready, 1);
    chk("R12 rx_valid", rx_valid, 0);
    chk("R12 sclk_out", sclk_out, 0);
    chk("R12 sel_out", sel_out, 1);
    chk("R11 sel_oe master", sel_oe, 1);

    // R1 R2 R5: divider sweep, master, no framing
    k = 0;
    for (int p = 0; p < 4; p++) begin
      for (int s = 0; s < 8; s++) begin
        if (p == 3 && s != 0 && s != 7) continue;
        pre_sel = 2'(p); sec_div = 3'(s);
        hw = 16'h8001 ^ 16'(k * 16'h2A57);
        bw = {hw[7:0], hw[15:8]} ^ 16'h5A5A;
        push(hw);
        mpoll(0, bw, got, per, selw, csb);
        chk("R1 period", per, 2 * (1 << (2 * p)) * (s + 1));
        chk("R2 sdo word", got, hw);
        chk("R4 rx_valid", rx_valid, 1);
        chk("R2 rx word", rx_data, bw);
        chk("R5 cs low in word", csb, 0);
        pop();
        @(negedge clk);
        chk("R5 cs idle high", sel_out, 1);
        chk("R1 clock idle low", sclk_out, 0);
        k++;
      end
    end

    // R3 R4: back-to-back words, receive side left unread
    pre_sel = 2'd1; sec_div = 3'd1;
    ha = 16'hC3A5; ba = 16'h1E2D; hb = 16'h0FF0; bb = 16'hB00B;
    push(ha);
    @(negedge clk);
    chk("R3 ready after take", tx_ready, 1);
    push(hb);
    chk("R3 held while busy", tx_ready, 0);
    mpoll(0, ba, got, per, selw, csb);
    chk("R2 word A", got, ha);
    chk("R3 B taken after A", tx_ready, 0);
    mpoll(0, bb, got, per, selw, csb);
    chk("R3 word B sent", got, hb);
    chk("R3 buffer empty", tx_ready, 1);
    chk("R4 first kept", rx_data, ba);
    pop();
    @(negedge clk);
    chk("R4 second dropped", rx_valid, 0);

    // R6: master, generated pulse
    frame_en = 1'b1; sync_in_mode = 1'b0; pre_sel = 2'd0; sec_div = 3'd2;
    @(negedge clk);
    chk("R11 sel_oe gen", sel_oe, 1);
    chk("R6 idle pulse low", sel_out, 0);
    hw = 16'h6D29; bw = 16'hA4F1;
    push(hw);
    mpoll(1, bw, got, per, selw, csb);
    chk("R6 pulse width", selw, 6);
    chk("R6 sdo word", got, hw);
    chk("R6 rx word", rx_data, bw);
    pop();

    // R7: master, received pulse
    sync_in_mode = 1'b1; pre_sel = 2'd1; sec_div = 3'd0; sel_in = 1'b0;
    @(negedge clk);
    chk("R11 sel_oe recv", sel_oe, 0);
    hw = 16'h3B71; bw = 16'hE00D;
    push(hw);
    mpoll(2, bw, got, per, selw, csb);
    chk("R7 sdo word", got, hw);
    chk("R7 rx word", rx_data, bw);
    pop();

    // R9 R2: slave, no framing
    master = 1'b0; frame_en = 1'b0; sel_in = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 sel_oe slave", sel_oe, 0);
    hw = 16'h9A5E; bw = 16'h47C2;
    push(hw);
    repeat (4) @(negedge clk);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      scyc(1'b0, bw[15-i], q, so);
      got = {got[14:0], q};
    end
    sel_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 slave sdo word", got, hw);
    chk("R9 slave rx word", rx_data, bw);
    pop();

    // R9 abort, then R10 zeros with empty transmit path
    hw = 16'hFFFF;
    push(hw);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 5; i++) scyc(1'b0, 1'b1, q, so);
    sel_in = 1'b1;
    repeat (10) @(negedge clk);
    chk("R9 abort no word", rx_valid, 0);
    bw = 16'h2C8B;
    got = '0;
    for (int i = 0; i < 16; i++) begin
      scyc(1'b0, bw[15-i], q, so);
      got = {got[14:0], q};
    end
    sel_in = 1'b1;
    repeat (8) @(negedge clk);
    chk("R10 zeros sent", got, 0);
    chk("R9 word after abort", rx_data, bw);
    pop();

    // R8: slave, received pulse
    frame_en = 1'b1; sync_in_mode = 1'b1; sel_in = 1'b0;
    hw = 16'h5E17; bw = 16'hD2B4;
    push(hw);
    repeat (4) @(negedge clk);
    for (int i = 0; i < 20; i++) scyc(1'b0, 1'b1, q, so);
    repeat (8) @(negedge clk);
    chk("R8 no pulse no word", rx_valid, 0);
    scyc(1'b1, 1'b0, q, so);
    got = '0;
    for (int i = 0; i < 16; i++) begin
      scyc((i == 5), bw[15-i], q, so);
      got = {got[14:0], q};
    end
    sel_in = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 sdo word", got, hw);
    chk("R8 rx word", rx_data, bw);
    pop();
    for (int i = 0; i < 18; i++) scyc(1'b0, 1'b1, q, so);
    repeat (8) @(negedge clk);
    chk("R8 mid pulse ignored", rx_valid, 0);

    // R6 slave side: generated pulse
    sync_in_mode = 1'b0;
    @(negedge clk);
    chk("R11 sel_oe slave gen", sel_oe, 1);
    hw = 16'hA0C5; bw = 16'h17E9;
    push(hw);
    repeat (4) @(negedge clk);
    scyc(1'b0, 1'b0, q, so);
    chk("R6 slave before pulse", so, 0);
    scyc(1'b0, 1'b0, q, so);
    chk("R6 slave pulse high", so, 1);
    got = '0; sel_hi_cnt = 0;
    for (int i = 0; i < 16; i++) begin
      scyc(1'b0, bw[15-i], q, so);
      got = {got[14:0], q};
      if (so) sel_hi_cnt++;
    end
    repeat (8) @(negedge clk);
    chk("R6 pulse one period", sel_hi_cnt, 0);
    chk("R6 slave sdo word", got, hw);
    chk("R6 slave rx word", rx_data, bw);
    pop();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule